// File: doc/BRIEF.md
# Radix-Adjusted Nibble Subtract Unit

This unit is one execution slice of a small 4-bit processor datapath. It carries out a family of subtract-with-borrow instructions. Each one takes a data-memory nibble away from the B register, together with the incoming carry, and folds the result back into a chosen number base. The base can be anything from 1 to 16 and is picked per instruction by a 4-bit field of the opcode. The carry flag reports a borrow against that base, and the zero flag reports a zero result. No other flag is touched.

Four encodings share the family. Opcode bit 5 picks the index register that forms the address (X or Y). Opcode bit 4 asks for that register to be stepped up by one after the access. A one-shot extension byte, written through a side port shortly before a non-stepping form, replaces the index-based address with a fixed page plus that byte. Each accepted instruction spends one cycle presenting the address with a read strobe. It spends a second cycle taking the returned nibble and committing B, the flags and any index step.

Top module: `radix_sub_unit`

## Requirements
- R1: An `issue` is accepted only when opcode bits [12:6] equal 1110011 and the unit is idle. Any other opcode causes no memory read and no register change.
- R2: After an accepted issue, `memRd` is high for exactly the next cycle and `busy` is high for two cycles. B, carry, zero and the index registers take their new values at the end of the second cycle.
- R3: Without a valid extension byte, the read address is X when opcode bit 5 is 0 and Y when it is 1.
- R4: With a valid extension byte and opcode bit 4 clear, the address is 0x00 followed by the byte for the X form, and 0xFF followed by the byte for the Y form.
- R5: The forms with opcode bit 4 set ignore the extension byte and address through the index register. Every completed instruction invalidates the extension byte, so a later instruction without a new byte uses its index register.
- R6: When B − operand − C is zero or positive, B receives that difference and carry is cleared.
- R7: When B − operand − C is negative, B receives the difference plus the radix and carry is set.
- R8: Opcode bits [3:0] give the radix directly for values 1 to 15. The code 0000 means radix 16.
- R9: The zero flag is set exactly when the 4-bit value written to B is zero.
- R10: With opcode bit 4 set, the selected index register is incremented by one and wraps from 0xFFFF to 0x0000. The other index register is unchanged. The increment affects no flag.
- R11: With opcode bit 4 clear, both index registers keep their values.
- R12: An issue presented while `busy` is high is ignored, and the running instruction completes unchanged.
- R13: Operands or B values at or above the radix give no error. The result is the low 4 bits of the corrected difference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Start request for the opcode on `opcode` |
| opcode | input | 13 | Instruction word |
| busy | output | 1 | High while an instruction is in flight |
| extLoad | input | 1 | Writes `extImm` and marks the extension byte valid |
| extImm | input | 8 | Extension byte |
| loadB | input | 1 | Writes loadData[3:0] into B |
| loadX | input | 1 | Writes loadData into X |
| loadY | input | 1 | Writes loadData into Y |
| loadC | input | 1 | Writes loadData[0] into the carry flag |
| loadData | input | 16 | Write data for the register load strobes |
| memRd | output | 1 | Data-memory read strobe |
| memAddr | output | 16 | Data-memory address, valid with `memRd` |
| memData | input | 4 | Read data, valid the cycle after `memRd` |
| bReg | output | 4 | B register |
| xReg | output | 16 | X index register |
| yReg | output | 16 | Y index register |
| flagC | output | 1 | Carry (borrow) flag |
| flagZ | output | 1 | Zero flag |

## Verification
Most internal faults show up within two cycles of an issue. A wrong sequencer state shows as a missing, doubled or early `memRd`, or as `busy` held for the wrong number of cycles. A stale extension-valid bit or a bad address select puts a wrong `memAddr` on the bus in the very cycle the strobe rises. Faults in the borrow correction or radix decode surface at the commit edge as a wrong B or carry value, but only for operand patterns that cross zero. The bench therefore pairs borrowing and non-borrowing cases at radices 1, 7, 10 and 16. An index step that lands on the wrong register, or that leaks into the flags, is visible on `xReg`, `yReg` and `flagZ` right after the second cycle.

// File: rtl/radix_sub_pkg.sv
package radix_sub_pkg;
  localparam int unsigned DATA_W = 4;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned EXT_W = 8;
  localparam int unsigned OPC_W = 13;

  // opcode layout
  localparam int unsigned FAM_LSB = 6;
  localparam int unsigned FAM_W = OPC_W - FAM_LSB;
  localparam logic [FAM_W-1:0] FAM_CODE = 7'b1110011;
  localparam int unsigned IDX_SEL_BIT = 5;
  localparam int unsigned POST_INC_BIT = 4;

  // extension pages
  localparam int unsigned PAGE_W = ADDR_W - EXT_W;
  localparam logic [PAGE_W-1:0] X_PAGE = '0;
  localparam logic [PAGE_W-1:0] Y_PAGE = '1;

  localparam int unsigned IDX_CNT = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } seqState_t;

  typedef struct packed {
    logic addrPhase;
    logic commit;
  } ctrlStrb_t;

  typedef struct packed {
    logic useY;
    logic postInc;
    logic [DATA_W-1:0] radixCode;
  } opFields_t;
endpackage

// File: rtl/radix_sub_ctrl.sv
module radix_sub_ctrl
  import radix_sub_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             issue,
  input  logic [OPC_W-1:0] opcode,
  output ctrlStrb_t        strb,
  output opFields_t        opQ,
  output logic             busy
);
  seqState_t stQ, stD;
  logic famMatch;
  logic accept;
  opFields_t opDecoded;

  assign famMatch = (opcode[OPC_W-1:FAM_LSB] == FAM_CODE);
  assign accept = issue && (stQ == ST_IDLE) && famMatch;

  assign opDecoded.useY = opcode[IDX_SEL_BIT];
  assign opDecoded.postInc = opcode[POST_INC_BIT];
  assign opDecoded.radixCode = opcode[DATA_W-1:0];

  always_comb begin
    stD = stQ;
    case (stQ)
      ST_IDLE: stD = accept ? ST_ADDR : ST_IDLE;
      ST_ADDR: stD = ST_DATA;
      ST_DATA: stD = ST_IDLE;
      default: stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ <= ST_IDLE;
      opQ <= '0;
    end else begin
      stQ <= stD;
      if (accept) opQ <= opDecoded;
    end
  end

  assign strb.addrPhase = (stQ == ST_ADDR);
  assign strb.commit = (stQ == ST_DATA);
  assign busy = (stQ != ST_IDLE);

  // R2: the address cycle is always followed by exactly one commit cycle
  assert_single_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.addrPhase |=> (strb.commit && !strb.addrPhase));

  // R2: an address cycle only follows an accepted issue
  assert_read_after_issue_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.addrPhase |-> $past(accept));

  // R1: a non-family opcode leaves the sequencer idle
  assert_decode_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((stQ == ST_IDLE) && !famMatch) |=> (stQ == ST_IDLE));

  // R12: the latched instruction is not replaced while in flight
  assert_op_held_R12: assert property (@(posedge clk) disable iff (!rstN)
    strb.addrPhase |=> $stable(opQ));
endmodule

// File: rtl/radix_sub_alu.sv
module radix_sub_alu
  import radix_sub_pkg::*;
(
  input  logic [DATA_W-1:0] minuend,
  input  logic [DATA_W-1:0] subtrahend,
  input  logic              borrowIn,
  input  logic [DATA_W-1:0] radixCode,
  output logic [DATA_W-1:0] diff,
  output logic              borrowOut,
  output logic              zero
);
  localparam int unsigned WIDE = DATA_W + 1;

  // the widest negative case (0 - max - 1) is exactly -2**DATA_W, so one
  // extra bit carries the sign
  logic signed [WIDE-1:0] rawDiff;
  logic [DATA_W-1:0] corr;

  assign rawDiff = $signed({1'b0, minuend}) - $signed({1'b0, subtrahend})
                 - $signed({{(WIDE-1){1'b0}}, borrowIn});
  assign borrowOut = rawDiff[WIDE-1];

  // code 0 stands for radix 2**DATA_W, which is 0 modulo the result width,
  // so the raw code is the correction for every radix
  assign corr = borrowOut ? radixCode : '0;
  assign diff = rawDiff[DATA_W-1:0] + corr;
  assign zero = (diff == '0);
endmodule

// File: rtl/radix_sub_dp.sv
module radix_sub_dp
  import radix_sub_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  opFields_t         opQ,
  input  logic              extLoad,
  input  logic [EXT_W-1:0]  extImm,
  input  logic              loadB,
  input  logic              loadX,
  input  logic              loadY,
  input  logic              loadC,
  input  logic [ADDR_W-1:0] loadData,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] bReg,
  output logic [ADDR_W-1:0] xReg,
  output logic [ADDR_W-1:0] yReg,
  output logic              flagC,
  output logic              flagZ
);
  logic [ADDR_W-1:0] idxQ [IDX_CNT];
  logic [IDX_CNT-1:0] idxLoad;
  logic [EXT_W-1:0] extQ;
  logic extValid;
  logic useExt;
  logic [ADDR_W-1:0] indexAddr;
  logic [ADDR_W-1:0] extAddr;
  logic [DATA_W-1:0] aluDiff;
  logic aluBorrow;
  logic aluZero;

  assign idxLoad = {loadY, loadX};

  for (genvar g = 0; g < IDX_CNT; g++) begin : g_idx
    logic incHere;
    assign incHere = strb.commit && opQ.postInc && (opQ.useY == 1'(g));
    always_ff @(posedge clk) begin
      if (!rstN) idxQ[g] <= '0;
      else if (incHere) idxQ[g] <= idxQ[g] + 1'b1;
      else if (idxLoad[g]) idxQ[g] <= loadData;
    end
  end

  assign xReg = idxQ[0];
  assign yReg = idxQ[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extQ <= '0;
      extValid <= 1'b0;
    end else if (extLoad) begin
      extQ <= extImm;
      extValid <= 1'b1;
    end else if (strb.commit) begin
      extValid <= 1'b0;
    end
  end

  assign useExt = extValid && !opQ.postInc;
  assign indexAddr = opQ.useY ? yReg : xReg;
  assign extAddr = {(opQ.useY ? Y_PAGE : X_PAGE), extQ};
  assign memAddr = useExt ? extAddr : indexAddr;
  assign memRd = strb.addrPhase;

  radix_sub_alu u_alu (
    .minuend   (bReg),
    .subtrahend(memData),
    .borrowIn  (flagC),
    .radixCode (opQ.radixCode),
    .diff      (aluDiff),
    .borrowOut (aluBorrow),
    .zero      (aluZero)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bReg <= '0;
      flagC <= 1'b0;
      flagZ <= 1'b0;
    end else if (strb.commit) begin
      bReg <= aluDiff;
      flagC <= aluBorrow;
      flagZ <= aluZero;
    end else begin
      if (loadB) bReg <= loadData[DATA_W-1:0];
      if (loadC) flagC <= loadData[0];
    end
  end

  // R6: no borrow when B covers operand plus carry
  assert_no_borrow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && ({1'b0, bReg} >= ({1'b0, memData} + {{DATA_W{1'b0}}, flagC})))
    |=> !flagC);

  // R7: borrow whenever operand plus carry exceeds B
  assert_borrow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && ({1'b0, bReg} < ({1'b0, memData} + {{DATA_W{1'b0}}, flagC})))
    |=> flagC);

  // R9: zero flag tracks the committed B value
  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (flagZ == (bReg == '0)));

  // R10: post-increment steps X by one with wrap
  assert_inc_wrap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && opQ.postInc && !opQ.useY) |=> (xReg == $past(xReg) + 1'b1));

  // R11: non-stepping forms leave both index registers alone
  assert_index_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !opQ.postInc && !loadX && !loadY) |=> ($stable(xReg) && $stable(yReg)));

  // R5: the extension byte is used at most once
  assert_ext_oneshot_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !extLoad) |=> !extValid);
endmodule

// File: rtl/radix_sub_unit.sv
module radix_sub_unit
  import radix_sub_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              issue,
  input  logic [OPC_W-1:0]  opcode,
  output logic              busy,
  input  logic              extLoad,
  input  logic [EXT_W-1:0]  extImm,
  input  logic              loadB,
  input  logic              loadX,
  input  logic              loadY,
  input  logic              loadC,
  input  logic [ADDR_W-1:0] loadData,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] bReg,
  output logic [ADDR_W-1:0] xReg,
  output logic [ADDR_W-1:0] yReg,
  output logic              flagC,
  output logic              flagZ
);
  ctrlStrb_t strb;
  opFields_t opQ;

  radix_sub_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .issue (issue),
    .opcode(opcode),
    .strb  (strb),
    .opQ   (opQ),
    .busy  (busy)
  );

  radix_sub_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .opQ     (opQ),
    .extLoad (extLoad),
    .extImm  (extImm),
    .loadB   (loadB),
    .loadX   (loadX),
    .loadY   (loadY),
    .loadC   (loadC),
    .loadData(loadData),
    .memRd   (memRd),
    .memAddr (memAddr),
    .memData (memData),
    .bReg    (bReg),
    .xReg    (xReg),
    .yReg    (yReg),
    .flagC   (flagC),
    .flagZ   (flagZ)
  );
endmodule

// File: tb/sim_radix_sub_unit.sv
module sim_radix_sub_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issue = 1'b0;
  logic [12:0] opcode = '0;
  logic busy;
  logic extLoad = 1'b0;
  logic [7:0] extImm = '0;
  logic loadB = 1'b0, loadX = 1'b0, loadY = 1'b0, loadC = 1'b0;
  logic [15:0] loadData = '0;
  logic memRd;
  logic [15:0] memAddr;
  logic [3:0] memData = '0;
  logic [3:0] bReg;
  logic [15:0] xReg, yReg;
  logic flagC, flagZ;

  logic [3:0] operandVal = '0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // synchronous data memory model: data returned the cycle after the strobe
  always @(posedge clk) if (memRd) memData <= operandVal;

  radix_sub_unit u0 (
    .clk(clk), .rstN(rstN), .issue(issue), .opcode(opcode), .busy(busy),
    .extLoad(extLoad), .extImm(extImm),
    .loadB(loadB), .loadX(loadX), .loadY(loadY), .loadC(loadC), .loadData(loadData),
    .memRd(memRd), .memAddr(memAddr), .memData(memData),
    .bReg(bReg), .xReg(xReg), .yReg(yReg), .flagC(flagC), .flagZ(flagZ)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic loadReg(input int sel, input logic [15:0] val);
    @(negedge clk);
    loadData = val;
    loadB = (sel == 0); loadC = (sel == 1); loadX = (sel == 2); loadY = (sel == 3);
    @(negedge clk);
    loadB = 0; loadC = 0; loadX = 0; loadY = 0;
  endtask

  task automatic setState(input logic [3:0] b, input logic c, input logic [15:0] x, input logic [15:0] y);
    loadReg(0, {12'h0, b});
    loadReg(1, {15'h0, c});
    loadReg(2, x);
    loadReg(3, y);
  endtask

  task automatic setExt(input logic [7:0] v);
    @(negedge clk); extLoad = 1; extImm = v;
    @(negedge clk); extLoad = 0;
  endtask

  task automatic runOp(input logic [12:0] op, input logic [3:0] operand, input logic [15:0] expAddr,
                       input logic [3:0] expB, input logic expC, input logic expZ, input string req);
    operandVal = operand;
    @(negedge clk); issue = 1; opcode = op;
    @(negedge clk); issue = 0;
    check(memRd === 1'b1 && busy === 1'b1, "R2 strobe in first cycle", {memRd, busy}, 2'b11);
    check(memAddr === expAddr, {req, " address"}, memAddr, expAddr);
    @(negedge clk);
    check(memRd === 1'b0 && busy === 1'b1, "R2 second cycle", {memRd, busy}, 2'b01);
    @(negedge clk);
    check(busy === 1'b0, "R2 done after two cycles", busy, 0);
    check(bReg === expB, {req, " B"}, bReg, expB);
    check(flagC === expC, {req, " carry"}, flagC, expC);
    check(flagZ === expZ, {req, " zero"}, flagZ, expZ);
  endtask

  task automatic testReset();
    check(busy === 0 && memRd === 0, "R2 reset idle", {busy, memRd}, 0);
    check(bReg === 0 && flagC === 0 && flagZ === 0, "R9 reset regs", {bReg, flagC, flagZ}, 0);
    check(xReg === 0 && yReg === 0, "R11 reset index", {xReg, yReg}, 0);
  endtask

  task automatic testNoBorrow();
    setState(4'd9, 1'b1, 16'h1234, 16'h0BEE);
    runOp(13'h1CCA, 4'd4, 16'h1234, 4'd4, 1'b0, 1'b0, "R6 R3 X form");
    check(xReg === 16'h1234 && yReg === 16'h0BEE, "R11 index kept", xReg, 16'h1234);
  endtask

  task automatic testBorrow();
    setState(4'd3, 1'b0, 16'h0001, 16'hABCD);
    runOp(13'h1CEA, 4'd5, 16'hABCD, 4'd8, 1'b1, 1'b0, "R7 R3 Y form decimal");
    check(yReg === 16'hABCD, "R11 Y kept", yReg, 16'hABCD);
  endtask

  task automatic testRadixEdges();
    setState(4'd0, 1'b1, 16'h0200, 16'h0);
    runOp(13'h1CC0, 4'd0, 16'h0200, 4'd15, 1'b1, 1'b0, "R8 radix 16 code");
    setState(4'd0, 1'b1, 16'h0200, 16'h0);
    runOp(13'h1CC1, 4'd0, 16'h0200, 4'd0, 1'b1, 1'b1, "R9 radix 1 zero");
    setState(4'd7, 1'b0, 16'h0200, 16'h0);
    runOp(13'h1CC0, 4'd7, 16'h0200, 4'd0, 1'b0, 1'b1, "R9 exact zero");
  endtask

  task automatic testTruncate();
    setState(4'd2, 1'b0, 16'h0300, 16'h0);
    runOp(13'h1CCA, 4'd12, 16'h0300, 4'd0, 1'b1, 1'b1, "R13 operand over radix");
    setState(4'd0, 1'b1, 16'h0300, 16'h0);
    runOp(13'h1CC1, 4'd15, 16'h0300, 4'd1, 1'b1, 1'b0, "R13 radix 1 wrap");
    setState(4'd15, 1'b0, 16'h0300, 16'h0);
    runOp(13'h1CCA, 4'd0, 16'h0300, 4'd15, 1'b0, 1'b0, "R13 B over radix");
  endtask

  task automatic testPostInc();
    setState(4'd6, 1'b0, 16'h0042, 16'hFFFF);
    runOp(13'h1CF7, 4'd2, 16'hFFFF, 4'd4, 1'b0, 1'b0, "R10 Y step");
    check(yReg === 16'h0000, "R10 Y wraps", yReg, 16'h0000);
    check(xReg === 16'h0042, "R10 X untouched", xReg, 16'h0042);
    setState(4'd1, 1'b0, 16'h00FF, 16'h5555);
    runOp(13'h1CD7, 4'd3, 16'h00FF, 4'd5, 1'b1, 1'b0, "R10 X step radix 7");
    check(xReg === 16'h0100 && yReg === 16'h5555, "R10 X steps only", xReg, 16'h0100);
  endtask

  task automatic testExtOverride();
    setState(4'd8, 1'b0, 16'h1111, 16'h2222);
    setExt(8'h5A);
    runOp(13'h1CC8, 4'd1, 16'h005A, 4'd7, 1'b0, 1'b0, "R4 X page");
    setExt(8'h3C);
    runOp(13'h1CE8, 4'd1, 16'hFF3C, 4'd6, 1'b0, 1'b0, "R4 Y page");
    check(xReg === 16'h1111 && yReg === 16'h2222, "R11 ext keeps index", yReg, 16'h2222);
  endtask

  task automatic testExtOneShot();
    setState(4'd5, 1'b0, 16'h0100, 16'h0);
    setExt(8'h77);
    runOp(13'h1CD9, 4'd2, 16'h0100, 4'd3, 1'b0, 1'b0, "R5 step form ignores ext");
    check(xReg === 16'h0101, "R5 step taken", xReg, 16'h0101);
    runOp(13'h1CC9, 4'd1, 16'h0101, 4'd2, 1'b0, 1'b0, "R5 ext consumed");
  endtask

  task automatic testBadOpcode();
    setState(4'd5, 1'b0, 16'h0400, 16'h0);
    operandVal = 4'd1;
    @(negedge clk); issue = 1; opcode = 13'h1C8A;
    @(negedge clk); opcode = 13'h0CCA;
    check(memRd === 0 && busy === 0, "R1 first bad opcode", {memRd, busy}, 0);
    @(negedge clk); issue = 0;
    check(memRd === 0 && busy === 0, "R1 second bad opcode", {memRd, busy}, 0);
    repeat (2) @(negedge clk);
    check(bReg === 4'd5 && flagC === 0 && xReg === 16'h0400, "R1 state kept", bReg, 4'd5);
  endtask

  task automatic testBusyIssue();
    setState(4'd9, 1'b0, 16'h0010, 16'h0020);
    operandVal = 4'd3;
    @(negedge clk); issue = 1; opcode = 13'h1CCA;
    @(negedge clk); opcode = 13'h1CF5;
    check(memRd === 1 && memAddr === 16'h0010, "R12 first op address", memAddr, 16'h0010);
    @(negedge clk);
    check(memRd === 0, "R12 no second strobe", memRd, 0);
    @(negedge clk); issue = 0;
    check(busy === 0 && bReg === 4'd6 && flagC === 0, "R12 first op result", bReg, 4'd6);
    @(negedge clk);
    check(memRd === 0 && busy === 0, "R12 second issue dropped", {memRd, busy}, 0);
    check(yReg === 16'h0020, "R12 no Y step", yReg, 16'h0020);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testNoBorrow();
    testBorrow();
    testRadixEdges();
    testTruncate();
    testPostInc();
    testExtOverride();
    testExtOneShot();
    testBadOpcode();
    testBusyIssue();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule